// File: doc/BRIEF.md
# Bus Master Controller for a Small Processor Core

This block is the single bus master that sits between a small processor core and a classic (non-pipelined) Wishbone bus. It serves three request sources: instruction fetch, data load and data store. One transfer runs at a time. A state machine picks the next request from its idle state, runs one single-beat cycle on the bus and waits for an acknowledge or an error response. It then hands a completion pulse and the read data back to the source that made the request, or it raises an error flag for that source.

The state machine also acts as the core's reset generator. While the external reset is high, the machine stays in its start state and holds the core reset output high. The core reset therefore falls exactly one clock after the external reset is released. A parameterised watchdog ends a transfer that gets no response and treats it as an error. Setting the parameter to zero switches the watchdog off.

Each source follows a valid/ready style handshake, and back-pressure comes entirely from the bus. A source raises its request together with its address (and, for stores, its data and byte enables). It keeps them steady until it sees its completion pulse or its error flag. The fetch source alone may change its address while its transfer is in flight. That transfer still finishes on the bus, but its data is discarded and no completion is reported. Read data is valid only in the cycle of the completion pulse.

Top module: `bus_master_ctrl`

## Requirements
- R1: While `rst` is high, `core_rst_o` is 1, `cyc_o`, `stb_o` and `we_o` are 0, `sel_o` is all ones, and no completion pulse or error flag is raised.
- R2: After `rst` falls, `core_rst_o` stays 1 until the next rising clock edge and is 0 from then on. No bus cycle starts before that edge.
- R3: From idle, a store request has priority over a load request, and a load request has priority over a fetch request. The address (and, for a store, the data and byte enables) is captured when the transfer starts and is driven on `adr_o`/`dat_o` for the whole transfer.
- R4: `cyc_o` and `stb_o` are 1 only during a fetch, load or store transfer. `we_o` is 1 only during a store transfer.
- R5: `sel_o` carries the captured store byte enables during a store transfer and is all ones at every other time, including idle.
- R6: `ack_i` during a transfer, with `err_i` low, gives a one-cycle completion pulse (`fetch_done_o`, `load_done_o` or `store_done_o`) for that source in the same cycle, with `rdata_o` equal to `dat_i`. The bus cycle ends at the next edge.
- R7: `err_i` during a transfer ends it and enters an error state that lasts exactly one cycle. In that cycle `cyc_o` is 0 and exactly the error flag of the failed source (`fetch_err_o`, `load_err_o` or `store_err_o`) is 1. `err_i` wins over `ack_i` if both are high.
- R8: The error flag names the source captured when the error arrived, even if the request inputs change between the error and the error cycle.
- R9: If `fetch_addr` differs from the captured fetch address when the fetch is acknowledged, `fetch_done_o` stays 0. The next fetch then starts with the new address.
- R10: With `TIMEOUT` greater than 0, a transfer that gets no response during `TIMEOUT` cycles enters the error state at the following edge and flags its source. With `TIMEOUT` equal to 0 the controller waits without limit.
- R11: An `ack_i` in the last cycle before the watchdog would expire completes the transfer normally, and no error flag follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous reset, active high |
| core_rst_o | output | 1 | Reset to the core, high while the controller is in its start state |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | AW | Fetch address |
| fetch_done_o | output | 1 | Fetch completion pulse |
| fetch_err_o | output | 1 | Fetch error flag |
| load_req | input | 1 | Data load request |
| load_addr | input | AW | Load address |
| load_done_o | output | 1 | Load completion pulse |
| load_err_o | output | 1 | Load error flag |
| store_req | input | 1 | Data store request |
| store_addr | input | AW | Store address |
| store_data | input | DW | Store data |
| store_be | input | DW/8 | Store byte enables |
| store_done_o | output | 1 | Store completion pulse |
| store_err_o | output | 1 | Store error flag |
| rdata_o | output | DW | Read data, valid with a fetch or load completion pulse |
| cyc_o | output | 1 | Bus cycle |
| stb_o | output | 1 | Bus strobe |
| we_o | output | 1 | Bus write enable |
| adr_o | output | AW | Bus address |
| dat_o | output | DW | Bus write data |
| sel_o | output | DW/8 | Bus byte selects |
| ack_i | input | 1 | Bus acknowledge |
| err_i | input | 1 | Bus error |
| dat_i | input | DW | Bus read data |

## Verification
The watchdog expiry and a real acknowledge can fall in the same cycle. The bench provokes this by holding a load unanswered until the watchdog counter sits on its final cycle and then raising `ack_i` in exactly that cycle. The result is judged correct if the load completion pulse appears and no error flag follows in the next cycle. A second overlap is an acknowledge in the same cycle as a fetch-address change. There the bench expects no fetch completion, and it expects a fresh fetch at the new address.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_IDLE,
    ST_RD_INSTR,
    ST_RD_DATA,
    ST_WR_DATA,
    ST_ERROR
  } bmc_state_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_FETCH,
    SRC_LOAD,
    SRC_STORE
  } bmc_src_e;
endpackage

// File: rtl/bmc_arbiter.sv
module bmc_arbiter
  import bmc_pkg::*;
(
  input  logic     store_req,
  input  logic     load_req,
  input  logic     fetch_req,
  output bmc_src_e pick
);
  // fixed priority: store, then load, then fetch
  always_comb begin
    if (store_req)      pick = SRC_STORE;
    else if (load_req)  pick = SRC_LOAD;
    else if (fetch_req) pick = SRC_FETCH;
    else                pick = SRC_NONE;
  end
endmodule

// File: rtl/bmc_timeout.sv
module bmc_timeout #(
  parameter int TIMEOUT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic resp,
  output logic expire
);
  generate
    if (TIMEOUT == 0) begin : g_off
      assign expire = 1'b0;
    end else begin : g_on
      localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
      localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || !active || resp) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
      end

      assign expire = active && !resp && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/bus_master_ctrl.sv
module bus_master_ctrl
  import bmc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TIMEOUT = 256
) (
  input  logic            clk,
  input  logic            rst,
  output logic            core_rst_o,
  input  logic            fetch_req,
  input  logic [AW-1:0]   fetch_addr,
  output logic            fetch_done_o,
  output logic            fetch_err_o,
  input  logic            load_req,
  input  logic [AW-1:0]   load_addr,
  output logic            load_done_o,
  output logic            load_err_o,
  input  logic            store_req,
  input  logic [AW-1:0]   store_addr,
  input  logic [DW-1:0]   store_data,
  input  logic [DW/8-1:0] store_be,
  output logic            store_done_o,
  output logic            store_err_o,
  output logic [DW-1:0]   rdata_o,
  output logic            cyc_o,
  output logic            stb_o,
  output logic            we_o,
  output logic [AW-1:0]   adr_o,
  output logic [DW-1:0]   dat_o,
  output logic [DW/8-1:0] sel_o,
  input  logic            ack_i,
  input  logic            err_i,
  input  logic [DW-1:0]   dat_i
);
  localparam int SW = DW / 8;

  bmc_state_e    state_q, state_d;
  bmc_src_e      pick, err_src_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] wdat_q;
  logic [SW-1:0] be_q;
  logic          in_xfer, expire, fail;

  bmc_arbiter u_arb (
    .store_req (store_req),
    .load_req  (load_req),
    .fetch_req (fetch_req),
    .pick      (pick)
  );

  assign in_xfer = (state_q == ST_RD_INSTR) || (state_q == ST_RD_DATA) ||
                   (state_q == ST_WR_DATA);

  bmc_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
    .clk    (clk),
    .rst    (rst),
    .active (in_xfer),
    .resp   (ack_i | err_i),
    .expire (expire)
  );

  assign fail = in_xfer && (err_i || expire);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_START: state_d = ST_IDLE;
      ST_IDLE: begin
        case (pick)
          SRC_STORE: state_d = ST_WR_DATA;
          SRC_LOAD:  state_d = ST_RD_DATA;
          SRC_FETCH: state_d = ST_RD_INSTR;
          default:   state_d = ST_IDLE;
        endcase
      end
      ST_RD_INSTR, ST_RD_DATA, ST_WR_DATA: begin
        if (fail)       state_d = ST_ERROR;
        else if (ack_i) state_d = ST_IDLE;
      end
      ST_ERROR: state_d = ST_IDLE;
      default:  state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_START;
      err_src_q <= SRC_NONE;
      adr_q     <= '0;
      wdat_q    <= '0;
      be_q      <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        case (pick)
          SRC_STORE: begin
            adr_q  <= store_addr;
            wdat_q <= store_data;
            be_q   <= store_be;
          end
          SRC_LOAD:  adr_q <= load_addr;
          SRC_FETCH: adr_q <= fetch_addr;
          default:   adr_q <= adr_q;
        endcase
      end
      // error source is captured from the running transfer, not live requests
      if (fail) begin
        case (state_q)
          ST_RD_INSTR: err_src_q <= SRC_FETCH;
          ST_RD_DATA:  err_src_q <= SRC_LOAD;
          default:     err_src_q <= SRC_STORE;
        endcase
      end
    end
  end

  assign core_rst_o = (state_q == ST_START);
  assign cyc_o      = in_xfer;
  assign stb_o      = in_xfer;
  assign we_o       = (state_q == ST_WR_DATA);
  assign adr_o      = adr_q;
  assign dat_o      = wdat_q;
  assign sel_o      = (state_q == ST_WR_DATA) ? be_q : {SW{1'b1}};
  assign rdata_o    = dat_i;

  // a fetch whose address moved while in flight is dropped
  assign fetch_done_o = (state_q == ST_RD_INSTR) && ack_i && !err_i &&
                        (fetch_addr == adr_q);
  assign load_done_o  = (state_q == ST_RD_DATA) && ack_i && !err_i;
  assign store_done_o = (state_q == ST_WR_DATA) && ack_i && !err_i;

  assign fetch_err_o = (state_q == ST_ERROR) && (err_src_q == SRC_FETCH);
  assign load_err_o  = (state_q == ST_ERROR) && (err_src_q == SRC_LOAD);
  assign store_err_o = (state_q == ST_ERROR) && (err_src_q == SRC_STORE);
endmodule

// File: rtl/bmc_checks.sv
module bmc_checks #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          core_rst_o,
  input logic          cyc_o,
  input logic          stb_o,
  input logic          we_o,
  input logic [SW-1:0] sel_o,
  input logic          fetch_done_o,
  input logic          load_done_o,
  input logic          store_done_o,
  input logic          fetch_err_o,
  input logic          load_err_o,
  input logic          store_err_o
);
  // R2
  core_rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |=> !core_rst_o);

  // R4
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (cyc_o && stb_o));

  // R5
  sel_idle_ones_chk: assert property (@(posedge clk) disable iff (rst)
    !we_o |-> (sel_o == {SW{1'b1}}));

  // R6
  done_ends_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_done_o || load_done_o || store_done_o) |=> !cyc_o);

  // R7
  err_single_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_err_o, load_err_o, store_err_o}));

  // R7
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_err_o || load_err_o || store_err_o) |=>
      !(fetch_err_o || load_err_o || store_err_o));

  // R7
  err_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_err_o || load_err_o || store_err_o) |-> !cyc_o);
endmodule

bind bus_master_ctrl bmc_checks #(.SW(DW/8)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .core_rst_o   (core_rst_o),
  .cyc_o        (cyc_o),
  .stb_o        (stb_o),
  .we_o         (we_o),
  .sel_o        (sel_o),
  .fetch_done_o (fetch_done_o),
  .load_done_o  (load_done_o),
  .store_done_o (store_done_o),
  .fetch_err_o  (fetch_err_o),
  .load_err_o   (load_err_o),
  .store_err_o  (store_err_o)
);

// File: tb/bus_master_ctrl_tb.sv
module bus_master_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_rst_o;
  logic fetch_req = 0, load_req = 0, store_req = 0;
  logic [AW-1:0] fetch_addr = '0, load_addr = '0, store_addr = '0;
  logic [DW-1:0] store_data = '0, dat_i = '0;
  logic [3:0] store_be = '0;
  logic fetch_done_o, fetch_err_o, load_done_o, load_err_o, store_done_o, store_err_o;
  logic [DW-1:0] rdata_o, dat_o;
  logic cyc_o, stb_o, we_o;
  logic [AW-1:0] adr_o;
  logic [3:0] sel_o;
  logic ack_i = 0, err_i = 0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_master_ctrl #(.AW(AW), .DW(DW), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .core_rst_o(core_rst_o),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_done_o(fetch_done_o), .fetch_err_o(fetch_err_o),
    .load_req(load_req), .load_addr(load_addr),
    .load_done_o(load_done_o), .load_err_o(load_err_o),
    .store_req(store_req), .store_addr(store_addr), .store_data(store_data),
    .store_be(store_be), .store_done_o(store_done_o), .store_err_o(store_err_o),
    .rdata_o(rdata_o), .cyc_o(cyc_o), .stb_o(stb_o), .we_o(we_o),
    .adr_o(adr_o), .dat_o(dat_o), .sel_o(sel_o),
    .ack_i(ack_i), .err_i(err_i), .dat_i(dat_i)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) step();
    #1;
    chk("R1 core_rst", core_rst_o, 1);
    chk("R1 cyc", {cyc_o, stb_o, we_o}, 0);
    chk("R1 sel", sel_o, 4'hF);
    chk("R1 flags", {fetch_done_o, load_done_o, store_done_o,
                     fetch_err_o, load_err_o, store_err_o}, 0);
    fetch_req = 1; fetch_addr = 32'h100;
    rst = 0;
    #1;
    chk("R2 core_rst held", core_rst_o, 1);
    step(); #1;
    chk("R2 core_rst low", core_rst_o, 0);
    chk("R2 no cycle yet", cyc_o, 0);
    fetch_req = 0;
    step(); #1;
    chk("R2 idle stays", cyc_o, 0);
  endtask

  task automatic t_priority();
    store_req = 1; store_addr = 32'hA0; store_data = 32'hDEADBEEF; store_be = 4'b0101;
    load_req = 1;  load_addr = 32'hB0;
    fetch_req = 1; fetch_addr = 32'hC0;
    step(); #1;
    chk("R3 store first", {we_o, adr_o}, {1'b1, 32'hA0});
    chk("R3 store data", dat_o, 32'hDEADBEEF);
    chk("R4 cyc stb", {cyc_o, stb_o}, 2'b11);
    chk("R5 sel be", sel_o, 4'b0101);
    ack_i = 1;
    #1;
    chk("R6 store done", {store_done_o, load_done_o, fetch_done_o}, 3'b100);
    step(); ack_i = 0; store_req = 0; #1;
    chk("R6 cycle ended", cyc_o, 0);
    step(); #1;
    chk("R3 load second", {we_o, adr_o}, {1'b0, 32'hB0});
    chk("R5 sel ones in read", sel_o, 4'hF);
    ack_i = 1; dat_i = 32'h12345678;
    #1;
    chk("R6 load done", {store_done_o, load_done_o, fetch_done_o}, 3'b010);
    chk("R6 rdata", rdata_o, 32'h12345678);
    step(); ack_i = 0; load_req = 0; #1;
    step(); #1;
    chk("R3 fetch last", {cyc_o, we_o, adr_o}, {2'b10, 32'hC0});
    ack_i = 1; dat_i = 32'hCAFE0001;
    #1;
    chk("R6 fetch done", {fetch_done_o, rdata_o}, {1'b1, 32'hCAFE0001});
    step(); ack_i = 0; fetch_req = 0; #1;
    chk("R4 idle no cycle", {cyc_o, stb_o, we_o}, 0);
    chk("R5 idle sel", sel_o, 4'hF);
  endtask

  task automatic t_error_latch();
    fetch_req = 1; fetch_addr = 32'h200;
    step(); #1;
    chk("R7 fetch running", cyc_o, 1);
    err_i = 1; ack_i = 1;
    #1;
    chk("R7 err beats ack", fetch_done_o, 0);
    step(); err_i = 0; ack_i = 0;
    fetch_req = 0; store_req = 1; store_addr = 32'h300; store_be = 4'hF;
    #1;
    chk("R8 fetch flagged", {fetch_err_o, load_err_o, store_err_o}, 3'b100);
    chk("R7 no cycle in error", cyc_o, 0);
    step(); store_req = 0; #1;
    chk("R7 error one cycle", {fetch_err_o, load_err_o, store_err_o}, 0);
    step(); #1;
  endtask

  task automatic t_discard();
    fetch_req = 1; fetch_addr = 32'h400;
    step(); #1;
    chk("R9 fetch addr", adr_o, 32'h400);
    fetch_addr = 32'h500; ack_i = 1;
    #1;
    chk("R9 stale fetch dropped", fetch_done_o, 0);
    step(); ack_i = 0; #1;
    chk("R9 back to idle", cyc_o, 0);
    step(); #1;
    chk("R9 refetch new addr", {cyc_o, adr_o}, {1'b1, 32'h500});
    ack_i = 1;
    #1;
    chk("R9 new fetch done", fetch_done_o, 1);
    step(); ack_i = 0; fetch_req = 0; #1;
  endtask

  task automatic t_timeout();
    store_req = 1; store_addr = 32'h600; store_be = 4'b0011;
    step(); #1;
    for (int i = 0; i < TMO - 1; i++) step();
    #1;
    chk("R10 still waiting", cyc_o, 1);
    step(); #1;
    chk("R10 timeout error", {fetch_err_o, load_err_o, store_err_o, cyc_o}, 4'b0010);
    store_req = 0;
    step(); #1;
    chk("R10 error cleared", store_err_o, 0);
  endtask

  task automatic t_ack_at_limit();
    load_req = 1; load_addr = 32'h700;
    step(); #1;
    for (int i = 0; i < TMO - 1; i++) step();
    ack_i = 1; dat_i = 32'h0BADF00D;
    #1;
    chk("R11 done at limit", {load_done_o, rdata_o}, {1'b1, 32'h0BADF00D});
    step(); ack_i = 0; load_req = 0; #1;
    chk("R11 no error after", {fetch_err_o, load_err_o, store_err_o, cyc_o}, 0);
    step(); #1;
    chk("R11 stays quiet", {load_err_o, cyc_o}, 0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_error_latch();
    t_discard();
    t_timeout();
    t_ack_at_limit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule